// File: doc/BRIEF.md
# Piecewise-Linear Gamma Lookup Unit

This unit maps each raw pixel of a streamed image to a 10-bit output. It does this through a programmable table of knee points, with linear interpolation between neighbouring knees. The upper byte of the 16-bit pixel selects a table entry. The lower byte is the fraction by which the stored slope is applied. Separate tables exist for each of four Bayer colour positions and each of four sub-channels, which are frames stacked vertically within one incoming frame.

All programming goes through one write port. A 2-bit selector chooses between the control register, the table port and the two height registers. The table port takes address words, which set a write pointer, and data words, which store an entry and advance the pointer. The control register sets the Bayer phase and enables the unit. It also chooses whether every frame is processed or only one frame after each trigger.

Top module: `gamma_pwl`

## Requirements
- R1: After reset `pix_out_vld` is 0, the Bayer shift is 0, enable is 1 and repetitive mode is 1. A frame that starts without any control write is therefore processed.
- R2: `cfg_sel` chooses the target of a write: 0 is control, 1 is the table port, 2 is the heights of sub-channels 0 and 1, and 3 is the height of sub-channel 2. A table word with bit 20 set is an address word. It sets the pointer to entry bits 7:0, colour bits 9:8 and sub-channel bits 11:10, and it stores nothing.
- R3: A table word with bit 20 clear is a data word. Bits 9:0 hold the knee, bits 16:10 hold a signed slope (-64..+63), and bit 17 set multiplies the slope by 16.
- R4: Each data word is stored at the pointer, and the entry field of the pointer then advances by one. It wraps from 255 to 0 and keeps the same colour and sub-channel.
- R5: The output is knee + floor(slope × fraction / 256), clamped to 0..1023. The entry is indexed by `pix_in[15:8]`, and the fraction is `pix_in[7:0]`.
- R6: The colour index is {row parity, column parity} XOR the Bayer shift.
  - Column parity is 0 on the pixel that carries a line start and toggles on every valid pixel.
  - Row parity is 0 on the first line of the frame and on the first line of each sub-channel, and toggles on every other line start.
- R7: A valid pixel presented in clock cycle t appears with `pix_out_vld` in cycle t+3.
- R8: Control bits: shift in bits 1:0, enable in bit 3, repetitive mode in bit 4. If enable is 0 when a frame starts, no pixel of that frame is output.
- R9: With repetitive mode 0, a frame is processed only if a write with bit 5 set (the trigger) came before its frame start. The first such frame uses up the trigger. All other frames are dropped.
- R10: The heights of sub-channels 0 and 1 are written minus 1, in bits 15:0 and 31:16 of height register 0. The height of sub-channel 2 is written minus 1, in bits 15:0 of height register 1. Sub-channel 3 covers all lines that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 table, 2 heights 0/1, 3 height 2 |
| cfg_wdata | input | 32 | Configuration write data |
| pix_in | input | 16 | Raw pixel: table index and fraction |
| pix_vld | input | 1 | Pixel valid |
| line_start | input | 1 | First pixel of a line (qualified by pix_vld) |
| frame_start | input | 1 | First pixel of a frame (qualified by pix_vld) |
| pix_out | output | 10 | Converted pixel |
| pix_out_vld | output | 1 | Converted pixel valid |

## Verification
The bench sweeps every one of the 65536 pixel codes through frames that cross all four sub-channel boundaries, and it rotates the Bayer shift from frame to frame. A slope sign error, a missing ×16 scale or a truncation toward zero would show up as off-by-some values on pixels with negative slopes. A missing clamp would show up as wrap-around near 0 and near 1023.

Tables are loaded from entry 200 so that the pointer must wrap. Idle cycles are placed inside lines, so a column parity that toggles on idle cycles would pick the wrong colour table. A row parity that is not restarted at a sub-channel boundary would do the same.

Single-shot and disabled frames are checked for stray output. A trigger that is never used up lets a second frame through.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  localparam int SUB_W  = 2;
  localparam int COL_W  = 2;
  localparam int KNEE_W = 10;
  localparam int DIFF_W = 7;
  localparam int NHGT   = 3;
  localparam int ENT_W  = KNEE_W + DIFF_W + 1;

  typedef struct packed {
    logic                     x16;
    logic signed [DIFF_W-1:0] diff;
    logic [KNEE_W-1:0]        knee;
  } knee_ent_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_TBL  = 2'd1,
    SEL_H01  = 2'd2,
    SEL_H2   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/gamma_pwl_tbl.sv
module gamma_pwl_tbl
  import gamma_pwl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_is_addr,
  input  logic [ENT_W-1:0]              wr_word,
  input  logic [SUB_W+COL_W+IDX_W-1:0]  rd_addr,
  output knee_ent_t                     rd_ent
);
  localparam int AW    = SUB_W + COL_W + IDX_W;
  localparam int DEPTH = 1 << AW;

  knee_ent_t        mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [IDX_W-1:0] wptr_ent;
  logic             data_wr;

  assign wptr_ent = wptr[IDX_W-1:0];
  assign data_wr  = wr_en && !wr_is_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (wr_en && wr_is_addr) begin
      wptr <= {wr_word[IDX_W+COL_W+SUB_W-1:IDX_W+COL_W],
               wr_word[IDX_W+COL_W-1:IDX_W],
               wr_word[IDX_W-1:0]};
    end else if (data_wr) begin
      wptr[IDX_W-1:0] <= wptr_ent + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[wptr] <= knee_ent_t'(wr_word);
    rd_ent <= mem[rd_addr];
  end

  p_ptr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (wptr_ent == IDX_W'($past(wptr_ent) + 1'b1)));
  p_ptr_keep_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (wptr[AW-1:IDX_W] == $past(wptr[AW-1:IDX_W])));
endmodule

// File: rtl/gamma_pwl_seq.sv
module gamma_pwl_seq
  import gamma_pwl_pkg::*;
#(
  parameter int HGT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bayer_shift,
  input  logic                    en,
  input  logic                    repet,
  input  logic                    trig,
  input  logic [NHGT*HGT_W-1:0]   hgt_m1,
  input  logic                    vld,
  input  logic                    ls,
  input  logic                    fs,
  output logic [SUB_W-1:0]        cur_sub,
  output logic [COL_W-1:0]        cur_color,
  output logic                    pass
);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NHGT);

  logic             col_q, row_q, frame_on, armed;
  logic [SUB_W-1:0] sub_q;
  logic [HGT_W-1:0] line_cnt, cur_cnt, sub_hgt;
  logic             frame_hit, line_hit, sub_end;
  logic             cur_row, cur_col, cur_on;

  assign frame_hit = fs && vld;
  assign line_hit  = (ls || fs) && vld;
  assign sub_hgt   = (sub_q == LAST_SUB) ? '0 : hgt_m1[sub_q*HGT_W +: HGT_W];
  assign sub_end   = (sub_q != LAST_SUB) && (line_cnt == sub_hgt);

  always_comb begin
    cur_sub = sub_q;
    cur_cnt = line_cnt;
    cur_row = row_q;
    if (frame_hit) begin
      cur_sub = '0;
      cur_cnt = '0;
      cur_row = 1'b0;
    end else if (line_hit) begin
      cur_sub = sub_end ? sub_q + 1'b1 : sub_q;
      cur_cnt = sub_end ? '0 : line_cnt + 1'b1;
      cur_row = sub_end ? 1'b0 : !row_q;
    end
  end

  assign cur_col   = line_hit ? 1'b0 : col_q;
  assign cur_on    = frame_hit ? (en && (repet || armed)) : frame_on;
  assign cur_color = {cur_row, cur_col} ^ bayer_shift;
  assign pass      = vld && cur_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= 1'b0;
      row_q    <= 1'b0;
      sub_q    <= '0;
      line_cnt <= '0;
      frame_on <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (vld) begin
        col_q    <= !cur_col;
        row_q    <= cur_row;
        sub_q    <= cur_sub;
        line_cnt <= cur_cnt;
        frame_on <= cur_on;
      end
      if (trig) armed <= 1'b1;
      else if (frame_hit && en && !repet) armed <= 1'b0;
    end
  end

  p_col_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> col_q);
  p_disabled_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_hit && !en) |=> !frame_on);
  p_trig_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_hit && en && !repet && !trig) |=> !armed);
endmodule

// File: rtl/gamma_pwl_calc.sv
module gamma_pwl_calc
  import gamma_pwl_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_in,
  input  knee_ent_t         ent,
  input  logic [FRAC_W-1:0] frac,
  output logic [KNEE_W-1:0] pix_out,
  output logic              vld_out
);
  localparam int EFF_W = DIFF_W + 5;
  localparam int PW    = EFF_W + FRAC_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << KNEE_W) - 1);

  function automatic logic [KNEE_W-1:0] interp(input knee_ent_t e,
                                               input logic [FRAC_W-1:0] f);
    logic signed [EFF_W-1:0] eff;
    logic signed [FRAC_W:0]  fs;
    logic signed [PW-1:0]    prod, sum;
    eff  = e.x16 ? {e.diff[DIFF_W-1], e.diff, 4'b0000} : EFF_W'(e.diff);
    fs   = {1'b0, f};
    prod = eff * fs;
    sum  = $signed({{(PW-KNEE_W){1'b0}}, e.knee}) + (prod >>> FRAC_W);
    if (sum < 0)         return '0;
    else if (sum > MAXV) return '1;
    else                 return sum[KNEE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out <= '0;
      vld_out <= 1'b0;
    end else begin
      vld_out <= vld_in;
      if (vld_in) pix_out <= interp(ent, frac);
    end
  end

  p_clamp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && ent.knee == '0 && ent.diff[DIFF_W-1]) |=> (pix_out == '0));
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pwl_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int IDX_W = 8,
  parameter int HGT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_vld,
  input  logic              line_start,
  input  logic              frame_start,
  output logic [KNEE_W-1:0] pix_out,
  output logic              pix_out_vld
);
  localparam int FRAC_W = PIX_W - IDX_W;
  localparam int AW     = SUB_W + COL_W + IDX_W;

  logic [1:0]            ctl_shift;
  logic                  ctl_en, ctl_repet, trig;
  logic [NHGT*HGT_W-1:0] hgt_m1;
  logic                  wr_ctl, wr_tbl;
  logic [SUB_W-1:0]      cur_sub;
  logic [COL_W-1:0]      cur_color;
  logic                  pass;
  logic [AW-1:0]         s1_addr;
  logic [FRAC_W-1:0]     s1_frac, s2_frac;
  logic                  s1_vld, s2_vld;
  knee_ent_t             s2_ent;

  assign wr_ctl = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTL);
  assign wr_tbl = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TBL);
  assign trig   = wr_ctl && cfg_wdata[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_shift <= 2'd0;
      ctl_en    <= 1'b1;
      ctl_repet <= 1'b1;
      hgt_m1    <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_sel))
        SEL_CTL: begin
          ctl_shift <= cfg_wdata[1:0];
          ctl_en    <= cfg_wdata[3];
          ctl_repet <= cfg_wdata[4];
        end
        SEL_H01: hgt_m1[2*HGT_W-1:0] <= {cfg_wdata[16 +: HGT_W], cfg_wdata[0 +: HGT_W]};
        SEL_H2:  hgt_m1[3*HGT_W-1:2*HGT_W] <= cfg_wdata[0 +: HGT_W];
        default: ;
      endcase
    end
  end

  gamma_pwl_seq #(.HGT_W(HGT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bayer_shift(ctl_shift), .en(ctl_en),
    .repet(ctl_repet), .trig(trig), .hgt_m1(hgt_m1), .vld(pix_vld),
    .ls(line_start), .fs(frame_start), .cur_sub(cur_sub),
    .cur_color(cur_color), .pass(pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      s1_addr <= '0;
      s1_frac <= '0;
      s2_frac <= '0;
    end else begin
      s1_vld  <= pass;
      s1_addr <= {cur_sub, cur_color, pix_in[PIX_W-1:FRAC_W]};
      s1_frac <= pix_in[FRAC_W-1:0];
      s2_vld  <= s1_vld;
      s2_frac <= s1_frac;
    end
  end

  gamma_pwl_tbl #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_tbl), .wr_is_addr(cfg_wdata[20]),
    .wr_word(cfg_wdata[ENT_W-1:0]), .rd_addr(s1_addr), .rd_ent(s2_ent)
  );

  gamma_pwl_calc #(.FRAC_W(FRAC_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .vld_in(s2_vld), .ent(s2_ent),
    .frac(s2_frac), .pix_out(pix_out), .vld_out(pix_out_vld)
  );

  p_out_needs_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_vld |-> $past(pix_vld, 3));
  p_no_out_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> !pix_out_vld);
endmodule

// File: tb/gamma_pwl_tb.sv
module gamma_pwl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] pix_in = '0;
  logic        pix_vld = 1'b0, line_start = 1'b0, frame_start = 1'b0;
  logic [9:0]  pix_out;
  logic        pix_out_vld;

  always #2 clk = ~clk;

  gamma_pwl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_vld(pix_vld),
    .line_start(line_start), .frame_start(frame_start),
    .pix_out(pix_out), .pix_out_vld(pix_out_vld)
  );

  int cyc = 0;
  int nchk = 0, nfail = 0, unexp = 0;
  int exp_v[64];
  int exp_c[64];
  int wr = 0, rd = 0, n = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // entry contents chosen so both clamps and the x16 scale are exercised
  function automatic int ent_knee(int s, int c, int i);
    return (i * 4 + c * 37 + s * 101) % 1024;
  endfunction
  function automatic int ent_diff(int s, int c, int i);
    return ((i * 13 + c * 5 + s * 3) % 128) - 64;
  endfunction
  function automatic int ent_x16(int s, int c, int i);
    return (i + c + s) % 2;
  endfunction

  function automatic int expect_val(int s, int c, int v);
    int i, f, eff, p, q, r;
    i = v / 256;
    f = v % 256;
    eff = ent_diff(s, c, i) * (ent_x16(s, c, i) != 0 ? 16 : 1);
    p = eff * f;
    q = (p - (((p % 256) + 256) % 256)) / 256;   // floor division
    r = ent_knee(s, c, i) + q;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && pix_out_vld && !done) begin
      if (rd == wr) begin
        unexp++; nchk++; nfail++;
        $display("FAIL R8/R9: unexpected output %0d, expected none", pix_out);
      end else begin
        nchk += 2;
        if (int'(pix_out) != exp_v[rd % 64]) begin
          nfail++;
          $display("FAIL R5: pixel #%0d got %0d expected %0d", rd, pix_out, exp_v[rd % 64]);
        end
        if (cyc != exp_c[rd % 64] + 3) begin
          nfail++;
          $display("FAIL R7: latency got %0d expected 3", cyc - exp_c[rd % 64]);
        end
        rd++;
      end
    end
  end

  task automatic cfg(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 32'(data);
    pix_vld = 1'b0; line_start = 1'b0; frame_start = 1'b0;
  endtask

  task automatic idle(int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      cfg_we = 1'b0; pix_vld = 1'b0; line_start = 1'b0; frame_start = 1'b0;
    end
  endtask

  // R6, R10: bench keeps its own line/sub-channel/parity bookkeeping
  task automatic run_frame(int shift, bit keep);
    int sub, start, rp, cp, color, v;
    for (int l = 0; l < 9; l++) begin
      sub   = (l < 2) ? 0 : (l < 5) ? 1 : (l < 6) ? 2 : 3;
      start = (sub == 0) ? 0 : (sub == 1) ? 2 : (sub == 2) ? 5 : 6;
      rp    = (l - start) % 2;
      for (int x = 0; x < 64; x++) begin
        if (x % 5 == 4) idle(1);
        cp    = x % 2;
        color = ((rp * 2) + cp) ^ shift;
        v     = (n * 40503) & 32'hFFFF;
        n++;
        @(negedge clk);
        cfg_we = 1'b0; pix_vld = 1'b1; pix_in = 16'(v);
        line_start = (x == 0); frame_start = (x == 0) && (l == 0);
        if (keep) begin
          exp_v[wr % 64] = expect_val(sub, color, v);
          exp_c[wr % 64] = cyc;
          wr++;
        end
      end
    end
    idle(4);
  endtask

  task automatic dropped_frame(int shift, string tag);
    int u0;
    u0 = unexp;
    run_frame(shift, 0);
    nchk++;
    if (unexp != u0) begin
      nfail++;
      $display("FAIL %s: dropped frame gave %0d outputs expected 0", tag, unexp - u0);
    end
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    nchk++;
    if (pix_out_vld !== 1'b0) begin
      nfail++;
      $display("FAIL R1: pix_out_vld got %b expected 0", pix_out_vld);
    end
    // R10: sub0 = 2 lines, sub1 = 3 lines, sub2 = 1 line, sub3 the rest
    cfg(2, (2 << 16) | 1);
    cfg(3, 0);
    // R2, R3, R4: each table loaded from entry 200, wrapping through 255 -> 0
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++) begin
        cfg(1, (1 << 20) | (s << 10) | (c << 8) | 200);
        for (int k = 0; k < 256; k++) begin
          int i;
          i = (200 + k) % 256;
          cfg(1, ent_knee(s, c, i) | ((ent_diff(s, c, i) & 127) << 10) |
                 (ent_x16(s, c, i) << 17));
        end
      end
    idle(2);
    // R1: defaults (shift 0, enabled, repetitive) process this frame
    run_frame(0, 1);
    // R5, R6: sweep all pixel codes with rotating Bayer shift (R8 bits)
    for (int f = 0; f < 114; f++) begin
      cfg(0, 32'h18 | (f % 4));
      run_frame(f % 4, 1);
    end
    // R9: single-shot without trigger, then with trigger, then trigger used up
    cfg(0, 32'h08);
    dropped_frame(0, "R9");
    cfg(0, 32'h28);
    run_frame(0, 1);
    dropped_frame(0, "R9");
    // R8: disabled frame is dropped
    cfg(0, 32'h10);
    dropped_frame(0, "R8");
    cfg(0, 32'h1A);
    run_frame(2, 1);
    idle(10);
    nchk++;
    if (rd != wr) begin
      nfail++;
      $display("FAIL R7: outputs received %0d expected %0d", rd, wr);
    end
    report();
  end
endmodule